// File: doc/BRIEF.md
# Accumulator Bank with Scaling and Activation

This block is a row-addressed storage bank in which every row carries `DIM` signed 32-bit elements. It holds partial sums for a matrix engine: result rows are written either as fresh values or added element-wise onto what the row already holds. Rows may arrive as full 32-bit elements or as packed 8-bit elements, and 8-bit elements are sign-extended before use.

Reads come in two forms. A full-width read returns the stored 32-bit values unchanged. A narrow read turns each element into an 8-bit quantised value for the next layer. Each element is first divided by a power of two using an arithmetic right shift that rounds to nearest, then saturated to the signed 8-bit range. An optional clamp is applied last: plain rectification, or rectification with an upper limit that the caller supplies in the 8-bit output domain.

An accumulating write commits one cycle after it is issued, because it must read the row before it writes it back. Results are forwarded to later writes and reads, so a caller can issue back-to-back operations to one address without losing an update.

Top module: `acc_bank`

## Requirements
- R1: After synchronous reset, `rd_valid` is low and every row reads back as all zeros.
- R2: A write with `wr_accum` low replaces the addressed row. A later full-width read of that row returns the written elements, with element i at `rd_data[32i+:32]`.
- R3: With `wr_narrow` high, element i of the write is taken from `wr_data[8i+:8]` as a signed byte and sign-extended to 32 bits. This applies to both overwrite and accumulate writes.
- R4: A write with `wr_accum` high adds each incoming element to the stored element at the same position, with the sum wrapping modulo 2^32.
- R5: Writes issued in consecutive cycles to the same address all take effect in issue order. Back-to-back accumulates sum together, and an overwrite that follows an accumulate replaces the accumulated result.
- R6: A read issued with `rd_en` produces `rd_valid` high, with its data, exactly two cycles later. The read sees every write issued in earlier cycles, but not a write issued in the same cycle.
- R7: In a narrow read, each element x with shift s becomes floor((x + 2^(s-1)) / 2^s), or x when s = 0, saturated to -128..127.
- R8: In a narrow read with `rd_act` = 1, any negative scaled value becomes 0.
- R9: In a narrow read with `rd_act` = 2, scaled values are clamped to the range from 0 up to the `relu6_cap` value sampled with the request, with the cap treated as unsigned.
- R10: A narrow read places element i at `rd_data[8i+:8]` and drives all higher bits to zero. `rd_act` values 0 and 3 apply no clamp.
- R11: A full-width read ignores `rd_shift`, `rd_act` and `relu6_cap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Row address of the write |
| wr_data | input | DIM*32 | Write row, packed 32-bit or low DIM bytes when narrow |
| wr_narrow | input | 1 | Write elements are 8-bit signed |
| wr_accum | input | 1 | Add into the stored row instead of replacing it |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Row address of the read |
| rd_narrow | input | 1 | Return scaled 8-bit elements |
| rd_shift | input | 5 | Power-of-two down-scale exponent for narrow reads |
| rd_act | input | 2 | Clamp select: 0/3 none, 1 rectify, 2 rectify with cap |
| relu6_cap | input | 8 | Upper clamp value for `rd_act` = 2 |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DIM*32 | Read result row |

## Verification
The assertions assume that `rd_en`, `rd_narrow`, `rd_act` and `relu6_cap` are held at known values, with `rd_en` low, throughout reset, because the output checks look two cycles back at the request fields. They also assume at most one write and one read per cycle, which follows from the port structure. The stimulus drives every input on the falling edge, keeps all requests low while reset is asserted, and chooses write and read collisions deliberately so that forwarding is exercised.

// File: rtl/acc_bank_pkg.sv
package acc_bank_pkg;

    localparam int ELEM_W   = 32;
    localparam int NARROW_W = 8;
    localparam int SHIFT_W  = $clog2(ELEM_W);

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_RELU  = 2'd1,
        ACT_RELU6 = 2'd2,
        ACT_PASS  = 2'd3
    } act_e;

    localparam logic signed [ELEM_W:0] SAT_HI = $signed((ELEM_W+1)'(2**(NARROW_W-1) - 1));
    localparam logic signed [ELEM_W:0] SAT_LO = -$signed((ELEM_W+1)'(2**(NARROW_W-1)));

    function automatic logic [ELEM_W-1:0] widen(input logic [NARROW_W-1:0] n);
        return {{(ELEM_W-NARROW_W){n[NARROW_W-1]}}, n};
    endfunction

    function automatic logic [NARROW_W-1:0] scale_sat(input logic signed [ELEM_W-1:0] x,
                                                      input logic [SHIFT_W-1:0] sh);
        logic signed [ELEM_W:0] wide;
        logic signed [ELEM_W:0] bias;
        logic signed [ELEM_W:0] shifted;
        wide = {x[ELEM_W-1], x};
        bias = '0;
        if (sh != '0)
            bias = $signed((ELEM_W+1)'(1) << (sh - SHIFT_W'(1)));
        shifted = (wide + bias) >>> sh;
        if (shifted > SAT_HI)
            return SAT_HI[NARROW_W-1:0];
        else if (shifted < SAT_LO)
            return SAT_LO[NARROW_W-1:0];
        return shifted[NARROW_W-1:0];
    endfunction

    function automatic logic [NARROW_W-1:0] activate(input logic [NARROW_W-1:0] v,
                                                     input act_e act,
                                                     input logic [NARROW_W-1:0] cap);
        logic signed [NARROW_W:0] v_w;
        logic signed [NARROW_W:0] cap_w;
        v_w   = {v[NARROW_W-1], v};
        cap_w = {1'b0, cap};
        case (act)
            ACT_RELU:  return (v_w < 0) ? '0 : v;
            ACT_RELU6: begin
                if (v_w < 0)
                    return '0;
                else if (v_w > cap_w)
                    return cap;
                return v;
            end
            default:   return v;
        endcase
    endfunction

endpackage

// File: rtl/acc_bank_store.sv
module acc_bank_store
    import acc_bank_pkg::*;
#(
    parameter int DIM   = 4,
    parameter int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int ROW_W = DIM * ELEM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [ROW_W-1:0] wr_row,
    input  logic             wr_accum,
    input  logic [AW-1:0]    rd_addr,
    output logic [ROW_W-1:0] rd_row
);

    logic [ROW_W-1:0] mem [DEPTH];

    // pending accumulate stage
    logic             pend_valid;
    logic [AW-1:0]    pend_addr;
    logic [ROW_W-1:0] pend_add;
    logic             pend_fwd;
    logic [ROW_W-1:0] pend_base;
    logic [ROW_W-1:0] base_row;
    logic [ROW_W-1:0] pend_sum;

    assign base_row = pend_fwd ? pend_base : mem[pend_addr];

    for (genvar e = 0; e < DIM; e++) begin : g_add
        assign pend_sum[e*ELEM_W +: ELEM_W] = base_row[e*ELEM_W +: ELEM_W]
                                            + pend_add[e*ELEM_W +: ELEM_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_add   <= '0;
            pend_fwd   <= 1'b0;
            pend_base  <= '0;
        end else begin
            if (pend_valid)
                mem[pend_addr] <= pend_sum;
            // a newer overwrite to the same row must win over the older sum
            if (wr_en && !wr_accum)
                mem[wr_addr] <= wr_row;
            pend_valid <= wr_en && wr_accum;
            pend_addr  <= wr_addr;
            pend_add   <= wr_row;
            pend_fwd   <= pend_valid && (pend_addr == wr_addr);
            pend_base  <= pend_sum;
        end
    end

    assign rd_row = (pend_valid && pend_addr == rd_addr) ? pend_sum : mem[rd_addr];

    AST_ACC_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && !(wr_en && !wr_accum && wr_addr == pend_addr))
        |=> mem[$past(pend_addr)] == $past(pend_sum)); // R4

    AST_OVERWRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_accum)
        |=> mem[$past(wr_addr)] == $past(wr_row)); // R5

endmodule

// File: rtl/acc_bank_lane.sv
module acc_bank_lane
    import acc_bank_pkg::*;
(
    input  logic [ELEM_W-1:0]   val,
    input  logic [SHIFT_W-1:0]  shift,
    input  act_e                act,
    input  logic [NARROW_W-1:0] cap,
    output logic [NARROW_W-1:0] q
);

    logic [NARROW_W-1:0] scaled;

    always_comb begin
        scaled = scale_sat($signed(val), shift);
        q      = activate(scaled, act, cap);
    end

endmodule

// File: rtl/acc_bank.sv
module acc_bank
    import acc_bank_pkg::*;
#(
    parameter int DIM   = 4,
    parameter int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int ROW_W = DIM * ELEM_W,
    localparam int NROW_W = DIM * NARROW_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [ROW_W-1:0]    wr_data,
    input  logic                wr_narrow,
    input  logic                wr_accum,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    input  logic                rd_narrow,
    input  logic [SHIFT_W-1:0]  rd_shift,
    input  logic [1:0]          rd_act,
    input  logic [NARROW_W-1:0] relu6_cap,
    output logic                rd_valid,
    output logic [ROW_W-1:0]    rd_data
);

    logic [ROW_W-1:0] wr_row;
    logic [ROW_W-1:0] raw_row;

    for (genvar e = 0; e < DIM; e++) begin : g_widen
        assign wr_row[e*ELEM_W +: ELEM_W] = wr_narrow ? widen(wr_data[e*NARROW_W +: NARROW_W])
                                                      : wr_data[e*ELEM_W +: ELEM_W];
    end

    acc_bank_store #(.DIM(DIM), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_row   (wr_row),
        .wr_accum (wr_accum),
        .rd_addr  (rd_addr),
        .rd_row   (raw_row)
    );

    // read stage 1: captured row and request fields
    typedef struct packed {
        logic                valid;
        logic                narrow;
        logic [SHIFT_W-1:0]  shift;
        act_e                act;
        logic [NARROW_W-1:0] cap;
    } rd_ctl_t;

    rd_ctl_t          s1_ctl;
    logic [ROW_W-1:0] s1_row;
    logic [NROW_W-1:0] lane_bus;
    logic [ROW_W-1:0] out_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctl <= '0;
            s1_row <= '0;
        end else begin
            s1_ctl.valid  <= rd_en;
            s1_ctl.narrow <= rd_narrow;
            s1_ctl.shift  <= rd_shift;
            s1_ctl.act    <= act_e'(rd_act);
            s1_ctl.cap    <= relu6_cap;
            s1_row        <= raw_row;
        end
    end

    for (genvar e = 0; e < DIM; e++) begin : g_lane
        acc_bank_lane u_lane (
            .val   (s1_row[e*ELEM_W +: ELEM_W]),
            .shift (s1_ctl.shift),
            .act   (s1_ctl.act),
            .cap   (s1_ctl.cap),
            .q     (lane_bus[e*NARROW_W +: NARROW_W])
        );
    end

    always_comb begin
        out_row = s1_row;
        if (s1_ctl.narrow) begin
            out_row = '0;
            out_row[NROW_W-1:0] = lane_bus;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= s1_ctl.valid;
            rd_data  <= out_row;
        end
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en, 2)); // R6

    AST_RD_ISSUE: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> ##1 rd_valid); // R6

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(rd_narrow, 2)) |-> rd_data[ROW_W-1:NROW_W] == '0); // R10

    for (genvar e = 0; e < DIM; e++) begin : g_act_chk
        AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (rst)
            (rd_valid && $past(rd_narrow, 2) && $past(rd_act, 2) == 2'd1)
            |-> !rd_data[e*NARROW_W + NARROW_W - 1]); // R8

        AST_RELU6_CAP: assert property (@(posedge clk) disable iff (rst)
            (rd_valid && $past(rd_narrow, 2) && $past(rd_act, 2) == 2'd2)
            |-> (!rd_data[e*NARROW_W + NARROW_W - 1]
                 && rd_data[e*NARROW_W +: NARROW_W] <= $past(relu6_cap, 2))); // R9
    end

endmodule

// File: tb/acc_bank_tb.sv
module acc_bank_tb;

    localparam int DIM   = 4;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int ROW_W = DIM * 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [ROW_W-1:0] wr_data = '0;
    logic             wr_narrow = 1'b0;
    logic             wr_accum = 1'b0;
    logic             rd_en = 1'b0;
    logic [AW-1:0]    rd_addr = '0;
    logic             rd_narrow = 1'b0;
    logic [4:0]       rd_shift = '0;
    logic [1:0]       rd_act = '0;
    logic [7:0]       relu6_cap = '0;
    logic             rd_valid;
    logic [ROW_W-1:0] rd_data;

    acc_bank #(.DIM(DIM), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_narrow(wr_narrow), .wr_accum(wr_accum),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_narrow(rd_narrow),
        .rd_shift(rd_shift), .rd_act(rd_act), .relu6_cap(relu6_cap),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #4 clk = ~clk; // 125 MHz

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] model [DEPTH][DIM];

    typedef struct {
        logic [ROW_W-1:0] data;
        int               due;
        string            tag;
    } exp_t;
    exp_t pending[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] ref_narrow(logic [31:0] x, int sh, int act, int cap);
        longint v;
        v = longint'($signed(x));
        if (sh > 0) v = v + (longint'(1) << (sh - 1));
        v = v >>> sh;
        if (v > 127) v = 127;
        if (v < -128) v = -128;
        if (act == 1 && v < 0) v = 0;
        if (act == 2) begin
            if (v < 0) v = 0;
            if (v > cap) v = cap;
        end
        return v[7:0];
    endfunction

    function automatic logic [ROW_W-1:0] row4(int a, int b, int c, int d);
        return {d[31:0], c[31:0], b[31:0], a[31:0]};
    endfunction

    function automatic logic [ROW_W-1:0] bytes4(int a, int b, int c, int d);
        logic [ROW_W-1:0] r;
        r = '0;
        r[31:0] = {d[7:0], c[7:0], b[7:0], a[7:0]};
        return r;
    endfunction

    // driver: one cycle with an optional write and an optional read
    task automatic step(bit we, int wa, logic [ROW_W-1:0] wd, bit wn, bit wacc,
                        bit re, int ra, bit rn, int sh, int act, int cap, string tag);
        exp_t ex;
        @(negedge clk);
        wr_en = we; wr_addr = wa[AW-1:0]; wr_data = wd; wr_narrow = wn; wr_accum = wacc;
        rd_en = re; rd_addr = ra[AW-1:0]; rd_narrow = rn; rd_shift = sh[4:0];
        rd_act = act[1:0]; relu6_cap = cap[7:0];
        if (re) begin
            ex.data = '0;
            for (int e = 0; e < DIM; e++) begin
                if (rn) ex.data[e*8 +: 8] = ref_narrow(model[ra][e], sh, act, cap);
                else    ex.data[e*32 +: 32] = model[ra][e];
            end
            ex.due = cyc + 2;
            ex.tag = tag;
            pending.push_back(ex);
        end
        if (we) begin
            for (int e = 0; e < DIM; e++) begin
                logic [31:0] inc;
                inc = wn ? {{24{wd[e*8+7]}}, wd[e*8 +: 8]} : wd[e*32 +: 32];
                model[wa][e] = wacc ? model[wa][e] + inc : inc;
            end
        end
    endtask

    task automatic wr(int a, logic [ROW_W-1:0] d, bit n, bit acc);
        step(1, a, d, n, acc, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic rd(int a, bit n, int sh, int act, int cap, string tag);
        step(0, 0, '0, 0, 0, 1, a, n, sh, act, cap, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                checks++;
                if (pending.size() == 0) begin
                    errors++;
                    $display("FAIL R6 unexpected rd_valid: actual 1 expected 0 at cycle %0d", cyc);
                end else begin
                    exp_t ex;
                    ex = pending.pop_front();
                    if (ex.due != cyc || rd_data !== ex.data) begin
                        errors++;
                        $display("FAIL %s: actual %h at cycle %0d expected %h at cycle %0d",
                                 ex.tag, rd_data, cyc, ex.data, ex.due);
                    end
                end
            end else if (pending.size() > 0 && pending[0].due <= cyc) begin
                exp_t ex;
                ex = pending.pop_front();
                checks++;
                errors++;
                $display("FAIL %s (R6 latency): actual no rd_valid expected %h at cycle %0d",
                         ex.tag, ex.data, ex.due);
            end
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++)
            for (int e = 0; e < DIM; e++) model[a][e] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 rd_valid after reset: actual %b expected 0", rd_valid);
        end
        rd(3, 0, 0, 0, 0, "R1 reset row 3");
        rd(15, 0, 0, 0, 0, "R1 reset row 15");

        // R2 overwrite and full-width read
        wr(1, row4(10, -20, 32'h7FFF_FFFF, 32'h8000_0000), 0, 0);
        rd(1, 0, 0, 0, 0, "R2 full row 1");
        // R3 narrow write sign extension
        wr(2, bytes4(8'h7F, 8'h80, 8'hFF, 8'h05), 1, 0);
        rd(2, 0, 0, 0, 0, "R3 narrow write row 2");
        // R4 accumulate with wrap
        wr(1, row4(1, 1, 1, -1), 0, 1);
        idle(1);
        rd(1, 0, 0, 0, 0, "R4 accumulate wrap row 1");
        wr(2, bytes4(8'hFE, 8'h01, 8'h02, 8'h80), 1, 1);
        idle(1);
        rd(2, 0, 0, 0, 0, "R3 narrow accumulate row 2");

        // R5 back-to-back accumulates, read forwarded next cycle
        wr(4, row4(1, 2, 3, 4), 0, 1);
        wr(4, row4(10, 20, 30, 40), 0, 1);
        wr(4, row4(100, 200, 300, -400), 0, 1);
        rd(4, 0, 0, 0, 0, "R5 forwarded triple accumulate row 4");
        rd(4, 0, 0, 0, 0, "R5 committed triple accumulate row 4");
        wr(5, row4(7, 7, 7, 7), 0, 0);
        wr(5, row4(5, 5, 5, 5), 0, 1);
        wr(5, row4(9, 8, 7, 6), 0, 0);
        idle(1);
        rd(5, 0, 0, 0, 0, "R5 overwrite after accumulate row 5");
        wr(6, row4(50, 60, 70, 80), 0, 0);
        wr(6, row4(1, 1, 1, 1), 0, 1);
        rd(6, 0, 0, 0, 0, "R5 accumulate after overwrite row 6");

        // R6 same-cycle read sees old data, next cycle sees new
        wr(7, row4(11, 12, 13, 14), 0, 0);
        step(1, 7, row4(21, 22, 23, 24), 0, 0, 1, 7, 0, 0, 0, 0, "R6 same-cycle read row 7");
        rd(7, 0, 0, 0, 0, "R6 following read row 7");
        step(1, 7, row4(1, 1, 1, 1), 0, 1, 1, 7, 0, 0, 0, 0, "R6 same-cycle accumulate row 7");
        rd(7, 0, 0, 0, 0, "R6 read after accumulate row 7");

        // R7 scaling, rounding, saturation
        wr(8, row4(3, -3, 1000, -1000), 0, 0);
        wr(9, row4(256, -256, 32'h7FFF_FFFF, 384), 0, 0);
        rd(8, 1, 0, 0, 0, "R7 shift 0 row 8");
        rd(8, 1, 1, 0, 0, "R7 shift 1 rounding row 8");
        rd(9, 1, 8, 0, 0, "R7 shift 8 row 9");
        rd(9, 1, 31, 0, 0, "R7 shift 31 row 9");
        rd(1, 1, 4, 0, 0, "R7 shift 4 row 1");
        // R8 / R9 / R10 activations
        rd(8, 1, 0, 1, 0, "R8 relu row 8");
        rd(1, 1, 2, 1, 0, "R8 relu row 1");
        rd(8, 1, 0, 2, 6, "R9 relu6 cap 6 row 8");
        rd(8, 1, 0, 2, 20, "R9 relu6 cap 20 row 8");
        rd(9, 1, 8, 2, 200, "R9 relu6 cap 200 row 9");
        rd(8, 1, 1, 3, 6, "R10 act code 3 row 8");
        rd(2, 1, 0, 0, 0, "R10 narrow packing row 2");
        // R11 full-width read ignores scaling fields
        rd(8, 0, 5, 1, 6, "R11 full read with shift and relu row 8");
        rd(9, 0, 9, 2, 3, "R11 full read with relu6 row 9");
        idle(5);

        checks++;
        if (pending.size() != 0) begin
            errors++;
            $display("FAIL R6 outstanding reads: actual %0d expected 0", pending.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule